// File: doc/BRIEF.md
# Thread-Grouped Performance Event Selector

This block picks which internal performance events reach a small bus of event output bits. Two hardware threads each present eight event lines. Each of the eight output lanes has its own 4-bit field in one 64-bit configuration register. The field's top bit chooses which thread's group of eight events feeds the lane. Its low three bits choose which one of the eight events drives the lane's output. The chosen bit is captured in a flop before it leaves the block, so a downstream counter sees a clean, registered signal.

Software reaches the register as special-purpose register number 913. There is one copy, shared by both threads. Both reading and writing require privileged state. A write without privilege is dropped and flagged with a one-cycle pulse. A read without privilege returns zero. The register comes out of reset as all zeros, so every lane starts out showing thread 0, event 0.

Top module: `thread_event_sel`

## Requirements
- R1: While reset is asserted and just after it, `event_o` is zero, `cfg_illegal_o` is low, and a privileged read of the register returns zero.
- R2: A write with `cfg_we_i` high, `cfg_priv_i` high and `cfg_addr_i` equal to 913 stores `cfg_wdata_i[31:0]`. Bits 63:32 of the written value are discarded. A write to any other address changes nothing.
- R3: With `cfg_re_i` high, `cfg_priv_i` high and address 913, `cfg_rdata_o` returns the stored value in bits 31:0 and zeros in bits 63:32, in the same cycle. A read at any other address returns zero.
- R4: A write to 913 with `cfg_priv_i` low leaves the register unchanged. It drives `cfg_illegal_o` high for exactly the one cycle after the write.
- R5: A read with `cfg_priv_i` low returns zero on `cfg_rdata_o`.
- R6: Lane i (0 to 7) takes its field from register bits [31-4i : 28-4i]. Bit 31-4i of that field is the group select, and bits [30-4i : 28-4i] are the event index, with the most significant bit first.
- R7: A group select of 0 routes `t0_events_i` to the lane. A group select of 1 routes `t1_events_i`.
- R8: An event index of k (0 to 7) drives bit k of the selected thread vector onto `event_o[i]`.
- R9: `event_o` reflects the event inputs sampled at the previous rising edge. A newly written configuration governs the capture at the edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| t0_events_i | input | 8 | Thread 0 event lines, bit k is event k |
| t1_events_i | input | 8 | Thread 1 event lines, bit k is event k |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe |
| cfg_addr_i | input | 10 | Special-purpose register number |
| cfg_wdata_i | input | 64 | Write data |
| cfg_priv_i | input | 1 | Access is privileged |
| cfg_rdata_o | output | 64 | Read data, zero unless a privileged read hits |
| cfg_illegal_o | output | 1 | One-cycle pulse after an unprivileged write |
| event_o | output | 8 | Registered selected event bits, one per lane |

## Verification
The assertions assume that the event vectors, the strobes and the privilege bit are stable around each rising edge and known after reset. The bench therefore changes every input only on the falling clock edge and never leaves a strobe undriven. The assertions also treat an unprivileged write as unprivileged regardless of its address. For that reason the bench issues unprivileged writes only to register 913, where the illegal pulse is defined. It then reads the register back to confirm that nothing changed.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int unsigned NUM_LANES  = 8;
  localparam int unsigned NUM_EVENTS = 8;
  localparam int unsigned IDX_W      = $clog2(NUM_EVENTS);
  localparam int unsigned FIELD_W    = IDX_W + 1;
  localparam int unsigned CFG_W      = NUM_LANES * FIELD_W;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned ADDR_W     = 10;
  localparam int unsigned SPR_NUM    = 913;

  typedef struct packed {
    logic             grp;
    logic [IDX_W-1:0] idx;
  } lane_cfg_t;
endpackage

// File: rtl/evsel_cfg_reg.sv
module evsel_cfg_reg #(
  parameter int unsigned ADDR_W  = evsel_pkg::ADDR_W,
  parameter int unsigned DATA_W  = evsel_pkg::DATA_W,
  parameter int unsigned CFG_W   = evsel_pkg::CFG_W,
  parameter int unsigned SPR_NUM = evsel_pkg::SPR_NUM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              illegal_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             illegal_q;
  logic             hit;
  logic             unused_hi;

  assign hit       = (addr_i == ADDR_W'(SPR_NUM));
  assign unused_hi = ^wdata_i[DATA_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (we_i && hit && priv_i) cfg_q <= wdata_i[CFG_W-1:0];
      illegal_q <= we_i && hit && !priv_i;
    end
  end

  // upper field bits are not stored and read back as zero
  assign rdata_o   = (re_i && hit && priv_i) ? DATA_W'(cfg_q) : '0;
  assign illegal_o = illegal_q;
  assign cfg_o     = cfg_q;

  // R4
  illegal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> $past(we_i && hit && !priv_i));
  // R4
  unpriv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(cfg_q));
  // R2
  priv_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i && hit) |=> (cfg_q == $past(wdata_i[CFG_W-1:0])));
endmodule

// File: rtl/evsel_lane.sv
module evsel_lane #(
  parameter int unsigned NUM_EVENTS = evsel_pkg::NUM_EVENTS,
  localparam int unsigned IDX_W     = $clog2(NUM_EVENTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  grp_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NUM_EVENTS-1:0] ev0_i,
  input  logic [NUM_EVENTS-1:0] ev1_i,
  output logic                  evt_o
);
  logic [NUM_EVENTS-1:0] bank;
  logic                  evt_q;

  // group select feeds the whole bank of 2:1 muxes
  genvar k;
  for (k = 0; k < NUM_EVENTS; k++) begin : g_bank
    assign bank[k] = grp_i ? ev1_i[k] : ev0_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= bank[idx_i];
  end

  assign evt_o = evt_q;

  // R7
  grp0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp_i && (ev0_i == '0)) |=> !evt_o);
  // R7
  grp1_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_i && (ev1_i == '1)) |=> evt_o);
endmodule

// File: rtl/thread_event_sel.sv
module thread_event_sel #(
  parameter int unsigned NUM_LANES  = evsel_pkg::NUM_LANES,
  parameter int unsigned NUM_EVENTS = evsel_pkg::NUM_EVENTS,
  parameter int unsigned ADDR_W     = evsel_pkg::ADDR_W,
  parameter int unsigned DATA_W     = evsel_pkg::DATA_W,
  parameter int unsigned SPR_NUM    = evsel_pkg::SPR_NUM,
  localparam int unsigned IDX_W     = $clog2(NUM_EVENTS),
  localparam int unsigned FIELD_W   = IDX_W + 1,
  localparam int unsigned CFG_W     = NUM_LANES * FIELD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_EVENTS-1:0] t0_events_i,
  input  logic [NUM_EVENTS-1:0] t1_events_i,
  input  logic                  cfg_we_i,
  input  logic                  cfg_re_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  input  logic                  cfg_priv_i,
  output logic [DATA_W-1:0]     cfg_rdata_o,
  output logic                  cfg_illegal_o,
  output logic [NUM_LANES-1:0]  event_o
);
  logic [CFG_W-1:0] cfg;

  evsel_cfg_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W),
    .SPR_NUM(SPR_NUM)
  ) cfg_reg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .re_i     (cfg_re_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .priv_i   (cfg_priv_i),
    .rdata_o  (cfg_rdata_o),
    .illegal_o(cfg_illegal_o),
    .cfg_o    (cfg)
  );

  // lane 0 sits in the most significant field (big-endian numbering)
  genvar i;
  for (i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [FIELD_W-1:0] fld;
    assign fld = cfg[CFG_W-1-FIELD_W*i -: FIELD_W];

    evsel_lane #(.NUM_EVENTS(NUM_EVENTS)) lane_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .grp_i (fld[FIELD_W-1]),
      .idx_i (fld[IDX_W-1:0]),
      .ev0_i (t0_events_i),
      .ev1_i (t1_events_i),
      .evt_o (event_o[i])
    );
  end

  // R5
  unpriv_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_priv_i |-> (cfg_rdata_o == '0));
endmodule

// File: tb/thread_event_sel_tb.sv
`timescale 1ns/1ps
module thread_event_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  t0 = '0, t1 = '0;
  logic        we = 1'b0, re = 1'b0, priv = 1'b0;
  logic [9:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        illegal;
  logic [7:0]  ev;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  thread_event_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .t0_events_i(t0), .t1_events_i(t1),
    .cfg_we_i(we), .cfg_re_i(re), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_priv_i(priv), .cfg_rdata_o(rdata), .cfg_illegal_o(illegal),
    .event_o(ev)
  );

  // {config, thread0 events, thread1 events}
  localparam logic [47:0] VEC [10] = '{
    {32'h0000_0000, 8'h01, 8'h00},
    {32'h0123_4567, 8'hA5, 8'h5A},
    {32'h89AB_CDEF, 8'h00, 8'hFF},
    {32'h7654_3210, 8'h3C, 8'hC3},
    {32'hFEDC_BA98, 8'h81, 8'h7E},
    {32'h1357_9BDF, 8'h55, 8'hAA},
    {32'hF0F0_0F0F, 8'hF0, 8'h0F},
    {32'h8888_0000, 8'h01, 8'h00},
    {32'h7777_FFFF, 8'h80, 8'h80},
    {32'h2A4C_6E19, 8'h96, 8'h69}
  };

  function automatic logic [7:0] model(input logic [31:0] c, input logic [7:0] a,
                                       input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] f;
      f = c[31-4*i -: 4];
      r[i] = f[3] ? b[f[2:0]] : a[f[2:0]];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d, input logic p);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    we = 1'b0; priv = 1'b1; addr = 10'd913;
  endtask

  task automatic rd_chk(input string req, input logic [63:0] exp);
    re = 1'b1; addr = 10'd913; priv = 1'b1;
    #0.5;
    chk(req, rdata, exp);
    re = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] c, input logic [7:0] a, input logic [7:0] b,
                         input string req);
    wr(10'd913, {32'hDEAD_BEEF, c}, 1'b1);
    t0 = a; t1 = b;
    @(negedge clk);
    chk(req, {56'b0, ev}, {56'b0, model(c, a, b)});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 event", {56'b0, ev}, 64'h0);
    chk("R1 illegal", {63'b0, illegal}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 readback", 64'h0);
    t0 = 8'h01; t1 = 8'hFE;
    @(negedge clk);
    chk("R1 lane default thread0 event0", {56'b0, ev}, 64'hFF);

    // table walk: R6 R7 R8, upper write bits R2, readback R3
    for (int n = 0; n < 10; n++) begin
      run_vec(VEC[n][47:16], VEC[n][15:8], VEC[n][7:0], "R6/R7/R8 table");
      rd_chk("R2/R3 readback", {32'b0, VEC[n][47:16]});
    end

    // random configs and events
    for (int n = 0; n < 40; n++) begin
      logic [31:0] c;
      logic [7:0] a, b;
      c = $urandom; a = $urandom; b = $urandom;
      run_vec(c, a, b, "R7/R8 random");
    end

    // R3 other address read returns zero
    wr(10'd913, 64'h0000_0000_1234_5678, 1'b1);
    re = 1'b1; addr = 10'd912; priv = 1'b1;
    #0.5; chk("R3 other addr read", rdata, 64'h0);
    re = 1'b0; addr = 10'd913;

    // R2 write to other address ignored
    wr(10'd914, 64'h0000_0000_FFFF_FFFF, 1'b1);
    rd_chk("R2 other addr write", 64'h1234_5678);

    // R5 unprivileged read
    re = 1'b1; priv = 1'b0;
    #0.5; chk("R5 unpriv read", rdata, 64'h0);
    re = 1'b0; priv = 1'b1;

    // R4 unprivileged write: ignored, one-cycle pulse
    @(negedge clk);
    chk("R4 illegal idle", {63'b0, illegal}, 64'h0);
    we = 1'b1; priv = 1'b0; wdata = 64'h0000_0000_8888_8888;
    @(negedge clk);
    chk("R4 illegal pulse", {63'b0, illegal}, 64'h1);
    we = 1'b0; priv = 1'b1;
    @(negedge clk);
    chk("R4 illegal one cycle", {63'b0, illegal}, 64'h0);
    rd_chk("R4 reg unchanged", 64'h1234_5678);

    // R9 latency: output holds until next edge, new config applies after write edge
    wr(10'd913, 64'h0, 1'b1);
    t0 = 8'h00; t1 = 8'h00;
    @(negedge clk);
    chk("R9 settle", {56'b0, ev}, 64'h0);
    t0 = 8'h01;
    #0.5; chk("R9 no combinational path", {56'b0, ev}, 64'h0);
    @(negedge clk);
    chk("R9 one cycle latency", {56'b0, ev}, 64'hFF);
    t1 = 8'h80;
    we = 1'b1; addr = 10'd913; wdata = 64'hFFFF_FFFF; priv = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R9 old config at write edge", {56'b0, ev}, 64'hFF);
    @(negedge clk);
    chk("R9 new config next edge", {56'b0, ev}, 64'hFF);
    t1 = 8'h00;
    @(negedge clk);
    chk("R9 follows thread1", {56'b0, ev}, 64'h00);

    // R6 single lane 5 field at bits 11:8 -> thread1 event 2
    wr(10'd913, 64'h0000_0A00, 1'b1);
    t0 = 8'h01; t1 = 8'h04;
    @(negedge clk);
    chk("R6 lane5 field", {56'b0, ev}, 64'hFF);
    t1 = 8'h00;
    @(negedge clk);
    chk("R6 lane5 only", {56'b0, ev}, 64'hDF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule